// File: doc/BRIEF.md
# Way-Partitioned Cache QoS Allocator

This unit sits beside one slice of a shared set-associative last-level cache and decides where fills may land. Every access arrives with a QoS domain identifier and a flag that says whether it is an instruction or a data access. For each identifier and each of the two access classes, a programmable way mask limits which ways a fill may replace. Lookups that hit are never restricted by the mask. They only refresh the replacement state.

On a miss the unit picks a victim way inside the allowed set. An invalid allowed way wins first. Otherwise a recently-used-bit pseudo-LRU chooses among the allowed ways. An empty mask makes the request bypass the cache. For each line the unit records which identifier allocated it. It keeps one occupancy counter per identifier, so the owner that gains a line and the owner that loses it are updated together.

A small register port lets software program the masks and read the counters. The tag and data arrays live outside the unit, and so does the mapping of clients to identifiers.

Top module: `qos_way_alloc`

## Requirements
- R1: After reset no line is valid, `fill_valid` and `fill_bypass` are 0, every occupancy counter reads 0 and every way mask reads all ones.
- R2: A request with `acc_hit`=1 allocates nothing. It raises neither `fill_valid` nor `fill_bypass` and leaves the counters unchanged, even when the requester's mask is all zero.
- R3: A fill lands only in a way whose bit is set in the mask selected by the requester's identifier and class. Mask bit i allows way i, and `acc_instr`=1 selects the instruction mask while 0 selects the data mask.
- R4: When at least one allowed way of the set is invalid, the fill takes the lowest-numbered such way.
- R5: A miss whose selected mask is all zero gives `fill_bypass`=1 with `fill_valid`=0 and changes no line and no counter.
- R6: Each way of a set has a recently-used bit. A hit or fill sets the bit of that way, and if that would set every bit of the set, all bits except that way's are cleared. When all allowed ways are valid, the victim is the lowest allowed way whose bit is clear, or the lowest allowed way if none is clear.
- R7: On a fill, the counter of the requesting identifier increases by one. If the victim was valid, the counter of its recorded owner decreases by one in the same cycle, so the net change is zero when the two are equal.
- R8: A mask write takes effect from the next fill. A fill requested in the same cycle as the write uses the old mask, and lines already held stay valid and keep their counts.
- R9: Register map with `cfg_addr` = {region, id, class}. Region bit (MSB) 0 holds the masks, with the LSB class set to 1 for instruction. Region 1 holds the counters, read-only, where writes are ignored and the LSB is don't-care. `cfg_rdata` is combinational from `cfg_addr`, zero-extended.
- R10: `fill_valid`, `fill_way` and `fill_bypass` are registered. They appear in the cycle after the request and last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_set | input | SET_W | Set index of the access |
| acc_qos | input | QOS_W | QoS domain identifier |
| acc_instr | input | 1 | 1 = instruction access, 0 = data access |
| acc_hit | input | 1 | Lookup hit in the tag array |
| acc_hit_way | input | WAY_W | Way that hit |
| fill_valid | output | 1 | Fill allocated into `fill_way` |
| fill_way | output | WAY_W | Chosen victim way |
| fill_bypass | output | 1 | Miss served without allocation |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address {region, id, class} |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data |

## Verification
The two functions that can meet in one cycle are a mask write and a fill of the same identifier and class, and a fill that changes both a gaining and a losing occupancy counter. The bench drives the write and the miss on the same clock edge. It then judges that this fill obeyed the old mask and that the following fill obeys the new one. A fill by a second identifier into a full set held by the first one provokes the two-counter case, and the bench reads back both counters to see one fall and one rise together.

// File: rtl/qos_alloc_pkg.sv
// Shared encodings of the QoS allocator: access class and register region.
// Assumes the class bit is the address LSB and the region bit is the MSB.
package qos_alloc_pkg;
    typedef enum logic {
        CLS_DATA  = 1'b0,
        CLS_INSTR = 1'b1
    } acc_class_e;

    typedef enum logic {
        REG_MASKS    = 1'b0,
        REG_COUNTERS = 1'b1
    } reg_region_e;
endpackage

// File: rtl/qos_mask_table.sv
// Table of way masks, one per (identifier, class) pair, reset to all ones.
// Assumes the table index is {id, class}; writes land at the clock edge,
// so a lookup in the same cycle still sees the previous value.
module qos_mask_table #(
    parameter int NUM_WAYS = 4,
    parameter int NUM_QOS  = 4,
    localparam int QOS_W   = $clog2(NUM_QOS),
    localparam int ENTRIES = 2 * NUM_QOS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [QOS_W:0]      wr_idx,
    input  logic [NUM_WAYS-1:0] wr_mask,
    input  logic [QOS_W:0]      lk_idx,
    output logic [NUM_WAYS-1:0] lk_mask,
    input  logic [QOS_W:0]      rd_idx,
    output logic [NUM_WAYS-1:0] rd_mask
);
    logic [NUM_WAYS-1:0] mask_q [ENTRIES];

    // Hold and update the programmable masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mask_q[i] <= '1;
        end else if (wr_en) begin
            mask_q[wr_idx] <= wr_mask;
        end
    end

    // Two read ports: one for the access path, one for software.
    always_comb begin
        lk_mask = mask_q[lk_idx];
        rd_mask = mask_q[rd_idx];
    end
endmodule

// File: rtl/qos_victim_sel.sv
// Combinational victim choice inside the allowed ways of one set.
// Order: lowest invalid allowed way, else lowest allowed way whose
// recently-used bit is clear, else lowest allowed way; an empty mask bypasses.
module qos_victim_sel #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] allowed,
    input  logic [NUM_WAYS-1:0] valid_vec,
    input  logic [NUM_WAYS-1:0] used_vec,
    output logic [WAY_W-1:0]    victim,
    output logic                bypass
);
    function automatic logic [WAY_W-1:0] lowest_set(input logic [NUM_WAYS-1:0] v);
        logic [WAY_W-1:0] idx;
        idx = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (v[i]) idx = WAY_W'(i);
        end
        return idx;
    endfunction

    logic [NUM_WAYS-1:0] free_ok;
    logic [NUM_WAYS-1:0] cold_ok;

    // Rank the candidates and pick the first non-empty class.
    always_comb begin
        free_ok = allowed & ~valid_vec;
        cold_ok = allowed & ~used_vec;
        bypass  = (allowed == '0);
        if (free_ok != '0)      victim = lowest_set(free_ok);
        else if (cold_ok != '0) victim = lowest_set(cold_ok);
        else                    victim = lowest_set(allowed);
    end
endmodule

// File: rtl/qos_occupancy.sv
// One occupancy counter per identifier. A fill adds one to the new owner
// and removes one from the evicted owner in the same edge.
// Assumes the caller never removes from an empty counter.
module qos_occupancy #(
    parameter int NUM_QOS = 4,
    parameter int CNT_W   = 7,
    localparam int QOS_W  = $clog2(NUM_QOS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd,
    input  logic [QOS_W-1:0]         gain_id,
    input  logic                     lose_en,
    input  logic [QOS_W-1:0]         lose_id,
    output logic [NUM_QOS*CNT_W-1:0] occ_flat
);
    for (genvar g = 0; g < NUM_QOS; g++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic             inc;
        logic             dec;

        // Decode whether this identifier gains or loses a line.
        always_comb begin
            inc = upd && (gain_id == QOS_W'(g));
            dec = upd && lose_en && (lose_id == QOS_W'(g));
        end

        // Apply the net change for this identifier.
        always_ff @(posedge clk) begin
            if (!rst_n)          cnt_q <= '0;
            else if (inc && !dec) cnt_q <= cnt_q + 1'b1;
            else if (dec && !inc) cnt_q <= cnt_q - 1'b1;
        end

        assign occ_flat[g*CNT_W +: CNT_W] = cnt_q;
    end
endmodule

// File: rtl/qos_way_alloc.sv
// Top of the QoS way allocator for one cache slice. It keeps per-line
// valid, owner and recently-used state, and it registers the fill decision.
// Assumes the tag array supplies hit/way, and a hit never uses a bypass mask.
module qos_way_alloc
    import qos_alloc_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int NUM_QOS  = 4,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int QOS_W   = $clog2(NUM_QOS),
    localparam int CNT_W   = $clog2(NUM_SETS * NUM_WAYS + 1),
    localparam int DATA_W  = (NUM_WAYS > CNT_W) ? NUM_WAYS : CNT_W,
    localparam int ADDR_W  = QOS_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [SET_W-1:0]  acc_set,
    input  logic [QOS_W-1:0]  acc_qos,
    input  logic              acc_instr,
    input  logic              acc_hit,
    input  logic [WAY_W-1:0]  acc_hit_way,
    output logic              fill_valid,
    output logic [WAY_W-1:0]  fill_way,
    output logic              fill_bypass,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata
);
    logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
    logic [NUM_WAYS-1:0] used_q  [NUM_SETS];
    logic [QOS_W-1:0]    owner_q [NUM_SETS][NUM_WAYS];

    logic [NUM_WAYS-1:0]      req_mask;
    logic [NUM_WAYS-1:0]      sw_mask;
    logic [WAY_W-1:0]         vict_way;
    logic                     vict_bypass;
    logic [NUM_QOS*CNT_W-1:0] occ_flat;
    logic                     miss_req;
    logic                     hit_req;
    logic                     do_fill;
    logic                     old_valid;
    logic [QOS_W-1:0]         old_owner;
    logic                     touch;
    logic [WAY_W-1:0]         touch_way;
    logic [NUM_WAYS-1:0]      used_next;
    logic                     mask_wr;
    logic [QOS_W-1:0]         rd_id;

    assign mask_wr = cfg_we && (cfg_addr[ADDR_W-1] == REG_MASKS);

    qos_mask_table #(.NUM_WAYS(NUM_WAYS), .NUM_QOS(NUM_QOS)) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr),
        .wr_idx  (cfg_addr[ADDR_W-2:0]),
        .wr_mask (cfg_wdata[NUM_WAYS-1:0]),
        .lk_idx  ({acc_qos, acc_instr}),
        .lk_mask (req_mask),
        .rd_idx  (cfg_addr[ADDR_W-2:0]),
        .rd_mask (sw_mask)
    );

    qos_victim_sel #(.NUM_WAYS(NUM_WAYS)) u_victim (
        .allowed   (req_mask),
        .valid_vec (valid_q[acc_set]),
        .used_vec  (used_q[acc_set]),
        .victim    (vict_way),
        .bypass    (vict_bypass)
    );

    // Classify the request and look up the line about to be replaced.
    always_comb begin
        hit_req   = acc_valid && acc_hit;
        miss_req  = acc_valid && !acc_hit;
        do_fill   = miss_req && !vict_bypass;
        old_valid = valid_q[acc_set][vict_way];
        old_owner = owner_q[acc_set][vict_way];
        touch     = hit_req || do_fill;
        touch_way = hit_req ? acc_hit_way : vict_way;
    end

    // Next recently-used vector: mark the touched way, age the rest when full.
    always_comb begin
        used_next = used_q[acc_set] | (NUM_WAYS'(1) << touch_way);
        if (used_next == '1) used_next = NUM_WAYS'(1) << touch_way;
    end

    qos_occupancy #(.NUM_QOS(NUM_QOS), .CNT_W(CNT_W)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (do_fill),
        .gain_id  (acc_qos),
        .lose_en  (old_valid),
        .lose_id  (old_owner),
        .occ_flat (occ_flat)
    );

    // Update line state and register the fill decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                valid_q[s] <= '0;
                used_q[s]  <= '0;
                for (int w = 0; w < NUM_WAYS; w++) owner_q[s][w] <= '0;
            end
            fill_valid  <= 1'b0;
            fill_way    <= '0;
            fill_bypass <= 1'b0;
        end else begin
            if (touch) used_q[acc_set] <= used_next;
            if (do_fill) begin
                valid_q[acc_set][vict_way] <= 1'b1;
                owner_q[acc_set][vict_way] <= acc_qos;
            end
            fill_valid  <= do_fill;
            fill_way    <= do_fill ? vict_way : '0;
            fill_bypass <= miss_req && vict_bypass;
        end
    end

    // Software read mux: counters or masks, zero-extended.
    always_comb begin
        rd_id = cfg_addr[QOS_W:1];
        if (cfg_addr[ADDR_W-1] == REG_COUNTERS)
            cfg_rdata = DATA_W'(occ_flat[rd_id*CNT_W +: CNT_W]);
        else
            cfg_rdata = DATA_W'(sw_mask);
    end
endmodule

// File: rtl/qos_way_alloc_chk.sv
// Assertion checker for the QoS way allocator, attached through bind.
// Assumes it sees the mask looked up for the current request.
module qos_way_alloc_chk #(
    parameter int NUM_WAYS = 4,
    parameter int OCC_W    = 28,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_valid,
    input logic                acc_hit,
    input logic [NUM_WAYS-1:0] req_mask,
    input logic                fill_valid,
    input logic [WAY_W-1:0]    fill_way,
    input logic                fill_bypass,
    input logic [OCC_W-1:0]    occ_flat
);
    logic [NUM_WAYS-1:0] prev_mask;
    logic                prev_hit;

    // Remember the previous request's mask and hit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_mask <= '0;
            prev_hit  <= 1'b0;
        end else begin
            prev_mask <= req_mask;
            prev_hit  <= acc_valid && acc_hit;
        end
    end

    AST_FILL_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> prev_mask[fill_way]); // R3
    AST_BYPASS_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        fill_bypass |-> (prev_mask == '0)); // R5
    AST_FILL_XOR_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fill_bypass)); // R5
    AST_HIT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        prev_hit |-> (!fill_valid && !fill_bypass)); // R2
    AST_OCC_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |-> (occ_flat == $past(occ_flat))); // R7
endmodule

bind qos_way_alloc qos_way_alloc_chk #(
    .NUM_WAYS (NUM_WAYS),
    .OCC_W    (NUM_QOS * CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_hit     (acc_hit),
    .req_mask    (req_mask),
    .fill_valid  (fill_valid),
    .fill_way    (fill_way),
    .fill_bypass (fill_bypass),
    .occ_flat    (occ_flat)
);

// File: tb/qos_way_alloc_tb.sv
// Directed bench for the QoS way allocator: one task per scenario.
module qos_way_alloc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SET_W  = 4;
    localparam int WAY_W  = 2;
    localparam int QOS_W  = 2;
    localparam int DATA_W = 7;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic [SET_W-1:0]  acc_set = '0;
    logic [QOS_W-1:0]  acc_qos = '0;
    logic              acc_instr = 1'b0;
    logic              acc_hit = 1'b0;
    logic [WAY_W-1:0]  acc_hit_way = '0;
    logic              fill_valid;
    logic [WAY_W-1:0]  fill_way;
    logic              fill_bypass;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [DATA_W-1:0] cfg_wdata = '0;
    logic [DATA_W-1:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    qos_way_alloc u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_qos(acc_qos), .acc_instr(acc_instr), .acc_hit(acc_hit),
        .acc_hit_way(acc_hit_way), .fill_valid(fill_valid), .fill_way(fill_way),
        .fill_bypass(fill_bypass), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [ADDR_W-1:0] mask_addr(input int id, input int instr);
        return ADDR_W'(id * 2 + instr);
    endfunction

    function automatic logic [ADDR_W-1:0] cnt_addr(input int id);
        return ADDR_W'(8 + id * 2);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [ADDR_W-1:0] a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DATA_W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [ADDR_W-1:0] a, output int d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = int'(cfg_rdata);
    endtask

    task automatic check_reg(input string tag, input logic [ADDR_W-1:0] a, input int exp);
        int d;
        cfg_read(a, d);
        check(tag, d, exp);
    endtask

    // Drive one request for one cycle and return the registered result.
    task automatic access(input int set, input int id, input int instr, input int hit,
                          input int hway, output int fv, output int fw, output int fb);
        @(negedge clk);
        acc_valid = 1'b1; acc_set = SET_W'(set); acc_qos = QOS_W'(id);
        acc_instr = 1'(instr); acc_hit = 1'(hit); acc_hit_way = WAY_W'(hway);
        @(negedge clk);
        acc_valid = 1'b0; acc_hit = 1'b0;
        fv = int'(fill_valid); fw = int'(fill_way); fb = int'(fill_bypass);
    endtask

    task automatic expect_fill(input string tag, input int set, input int id,
                               input int instr, input int exp_way);
        int fv, fw, fb;
        access(set, id, instr, 0, 0, fv, fw, fb);
        check({tag, " fill_valid"}, fv, 1);
        check({tag, " fill_way"}, fw, exp_way);
        check({tag, " fill_bypass"}, fb, 0);
    endtask

    task automatic expect_bypass(input string tag, input int set, input int id, input int instr);
        int fv, fw, fb;
        access(set, id, instr, 0, 0, fv, fw, fb);
        check({tag, " fill_valid"}, fv, 0);
        check({tag, " fill_bypass"}, fb, 1);
    endtask

    task automatic t_reset;
        check("R1 fill_valid", int'(fill_valid), 0);
        check("R1 fill_bypass", int'(fill_bypass), 0);
        for (int q = 0; q < 4; q++) begin
            check_reg("R1 counter", cnt_addr(q), 0);
            check_reg("R1 data mask", mask_addr(q, 0), 15);
            check_reg("R1 instr mask", mask_addr(q, 1), 15);
        end
    endtask

    task automatic t_invalid_first;
        for (int w = 0; w < 4; w++) expect_fill("R4 invalid-first", 0, 0, 0, w);
        @(negedge clk);
        check("R10 fill_valid one cycle", int'(fill_valid), 0);
        check_reg("R7 qos0 count", cnt_addr(0), 4);
    endtask

    task automatic t_plru;
        int fv, fw, fb;
        expect_fill("R6 oldest after wrap", 0, 0, 0, 0);
        access(0, 0, 0, 1, 1, fv, fw, fb);
        check("R2 hit fill_valid", fv, 0);
        check("R2 hit fill_bypass", fb, 0);
        expect_fill("R6 skip recent", 0, 0, 0, 2);
        check_reg("R7 same owner net zero", cnt_addr(0), 4);
    endtask

    task automatic t_class_masks;
        cfg_write(mask_addr(1, 0), 12);
        cfg_write(mask_addr(1, 1), 3);
        check_reg("R9 mask readback", mask_addr(1, 0), 12);
        expect_fill("R3 data mask", 1, 1, 0, 2);
        expect_fill("R3 instr mask", 1, 1, 1, 0);
        expect_fill("R3 data mask next", 1, 1, 0, 3);
        expect_fill("R6 all allowed recent", 1, 1, 0, 2);
        check_reg("R7 qos1 count", cnt_addr(1), 3);
    endtask

    task automatic t_cross_evict;
        expect_fill("R7 cross-owner victim", 0, 1, 0, 3);
        check_reg("R7 loser count", cnt_addr(0), 3);
        check_reg("R7 gainer count", cnt_addr(1), 4);
    endtask

    task automatic t_bypass;
        cfg_write(mask_addr(2, 0), 0);
        expect_bypass("R5 empty mask", 2, 2, 0);
        check_reg("R5 no count", cnt_addr(2), 0);
        expect_fill("R3 other class allowed", 2, 2, 1, 0);
    endtask

    task automatic t_mask_update;
        int fv, fw, fb;
        cfg_write(mask_addr(1, 0), 0);
        check_reg("R8 lines kept", cnt_addr(1), 4);
        expect_bypass("R8 new mask used", 5, 1, 0);
        access(0, 2, 0, 1, 3, fv, fw, fb);
        check("R2 hit with empty mask valid", fv, 0);
        check("R2 hit with empty mask bypass", fb, 0);
        cfg_write(mask_addr(1, 0), 2);
        expect_fill("R8 reprogrammed mask", 1, 1, 0, 1);
        check_reg("R8 qos1 count", cnt_addr(1), 5);
    endtask

    // Mask write and fill of the same id/class in the same cycle.
    task automatic t_same_cycle;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = mask_addr(3, 0); cfg_wdata = 7'd4;
        acc_valid = 1'b1; acc_set = 4'd3; acc_qos = 2'd3; acc_instr = 1'b0; acc_hit = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        check("R8 same-cycle uses old mask valid", int'(fill_valid), 1);
        check("R8 same-cycle uses old mask way", int'(fill_way), 0);
        expect_fill("R8 following fill uses new mask", 3, 3, 0, 2);
        check_reg("R7 qos3 count", cnt_addr(3), 2);
    endtask

    task automatic t_counter_ro;
        cfg_write(cnt_addr(0), 85);
        check_reg("R9 counter write ignored", cnt_addr(0), 3);
        check_reg("R9 counter qos2", cnt_addr(2), 1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_invalid_first;
        t_plru;
        t_class_masks;
        t_cross_evict;
        t_bypass;
        t_mask_update;
        t_same_cycle;
        t_counter_ro;
        finish_run;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end
endmodule